// File: doc/BRIEF.md
# Three-Channel Comparator Event Timer

This block is the counting and event core of a high-precision event timer. A 64-bit main counter advances once every sixteen clock cycles while a global enable is set; it freezes while the enable is clear and can be loaded by a write. Three comparator channels watch the counter. Each channel can run in one of two modes. In one-shot mode it fires once per match. In periodic mode it rearms itself by stepping its comparator forward by a stored period.

Each channel can also narrow its comparison and storage to the low 32 bits. When a channel fires, it produces a single-cycle pulse on one of 32 interrupt lines and sets a sticky status bit. The line comes from a five-bit route field. A global legacy-route mode overrides it, sending channel 0 to line 0 and channel 1 to line 8.

Software reaches the block through a single-cycle write port and a combinational read port. On each, a small target code selects the register and a channel index selects the channel.

Top module: `evtmr_top`

## Requirements
- R1: While global enable (global config bit 0) is set, the main counter increases by exactly one every 16 clock cycles. While global enable is clear, the counter holds its value.
- R2: After reset the main counter, global config, status and every channel config and period read zero, and every comparator reads all ones. A counter write loads the full 64-bit value.
- R3: A comparator write to a channel in 32-bit mode (channel config bit 8) stores only the low 32 bits; the upper half reads zero.
- R4: A comparator write while the channel's direct-set bit (config bit 6) is one changes only the comparator, leaves the period unchanged, and clears the direct-set bit.
- R5: A comparator write to a periodic channel (config bit 3) with direct-set clear also loads the period from the written value. The period has bit 31 cleared in 32-bit mode, or bit 63 cleared in 64-bit mode.
- R6: A config write that sets 32-bit mode clears the upper 32 bits of that channel's stored comparator and period.
- R7: A channel whose enable bit (config bit 2) is set fires when global enable is set and the comparator equals the counter, comparing only the low 32 bits in 32-bit mode. One cycle after the match becomes visible, its interrupt line pulses high for exactly one cycle and its status bit becomes one.
- R8: When a periodic channel with a non-zero period fires, its comparator advances by one period, wrapping at 32 bits in 32-bit mode. It fires again each time the counter reaches the new value.
- R9: A one-shot channel produces one pulse per match, even though the counter holds the matching value for 16 cycles. It is rearmed only by a comparator write or a counter write.
- R10: A channel drives the line given by its route field (config bits 13:9). When legacy route (global config bit 1) is set, channel 0 drives line 0 and channel 1 drives line 8, while channel 2 still follows its route field.
- R11: A status write clears each status bit whose corresponding data bit is one and leaves the other status bits unchanged.
- R12: Only global config bits 1:0 and channel config bits 2, 3, 6, 8 and 13:9 are writable; all other config bits read zero.
- R13: Write target codes are 0 global config, 1 counter, 2 channel config, 3 comparator, 4 status. Read codes are 0 global config, 1 counter, 2 channel config, 3 comparator, 4 period, 5 status (bit n for channel n). The channel index selects the channel, and unused read codes return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe, one write per cycle |
| wrTarget | input | 3 | Write target code |
| wrChan | input | 2 | Channel index for channel writes |
| wrData | input | 64 | Write data |
| rdTarget | input | 3 | Read target code |
| rdChan | input | 2 | Channel index for channel reads |
| rdData | output | 64 | Combinational read data |
| irqOut | output | 32 | Edge interrupt lines, one-cycle pulses |

## Verification
The assertions assume that software makes at most one write per cycle, so a channel never sees a config write and a comparator write on the same edge. They also assume that channel indices stay below three. The bench issues every write through a single task that raises the write strobe for exactly one cycle, and it draws channel indices modulo three. Random traffic runs with global enable clear, so register side effects can be checked without interference from firing. The firing, rearming and routing cases are then run as directed sequences with known counter starting points.

// File: rtl/evtmr_pkg.sv
package evtmr_pkg;

  localparam int WORD_W     = 64;
  localparam int ROUTE_W    = 5;
  localparam int NUM_IRQ    = 1 << ROUTE_W;
  localparam int CFG_W      = 16;

  // global configuration bit positions
  localparam int G_EN       = 0;
  localparam int G_LEGACY   = 1;

  // channel configuration bit positions
  localparam int C_EN       = 2;
  localparam int C_PERIODIC = 3;
  localparam int C_SETVAL   = 6;
  localparam int C_NARROW   = 8;
  localparam int C_ROUTE_LO = 9;

  localparam logic [CFG_W-1:0] C_WMASK = 16'h3F4C;

  localparam int LEGACY_LINE0 = 0;
  localparam int LEGACY_LINE1 = 8;

  typedef enum logic [2:0] {
    WT_GCFG   = 3'd0,
    WT_COUNT  = 3'd1,
    WT_CHCFG  = 3'd2,
    WT_CHCMP  = 3'd3,
    WT_STATUS = 3'd4
  } wrTarget_e;

  typedef enum logic [2:0] {
    RT_GCFG   = 3'd0,
    RT_COUNT  = 3'd1,
    RT_CHCFG  = 3'd2,
    RT_CHCMP  = 3'd3,
    RT_PERIOD = 3'd4,
    RT_STATUS = 3'd5
  } rdTarget_e;

  typedef struct packed {
    logic gCfgWr;
    logic cntWr;
    logic chCfgWr;
    logic chCmpWr;
    logic statWr;
  } strobes_t;

endpackage

// File: rtl/evtmr_ctrl.sv
module evtmr_ctrl
  import evtmr_pkg::*;
#(
  parameter int NUM_CH   = 3,
  parameter int PRESCALE = 16,
  parameter int CH_IDX_W = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wrEn,
  input  logic [2:0]          wrTarget,
  input  logic [CH_IDX_W-1:0] wrChan,
  input  logic                gEn,
  output strobes_t            stb,
  output logic [NUM_CH-1:0]   chSel,
  output logic                tick
);

  localparam int PRE_W = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(PRESCALE - 1);

  logic [PRE_W-1:0] preCnt;

  always_comb begin
    stb.gCfgWr  = wrEn && (wrTarget == WT_GCFG);
    stb.cntWr   = wrEn && (wrTarget == WT_COUNT);
    stb.chCfgWr = wrEn && (wrTarget == WT_CHCFG);
    stb.chCmpWr = wrEn && (wrTarget == WT_CHCMP);
    stb.statWr  = wrEn && (wrTarget == WT_STATUS);
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_sel
    assign chSel[i] = (wrChan == CH_IDX_W'(i));
  end

  assign tick = gEn && (preCnt == PRE_LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      preCnt <= '0;
    end else if (stb.cntWr || !gEn || tick) begin
      preCnt <= '0;
    end else begin
      preCnt <= preCnt + 1'b1;
    end
  end

  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick); // R1

  AST_TICK_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !gEn |-> !tick); // R1

endmodule

// File: rtl/evtmr_chan.sv
module evtmr_chan
  import evtmr_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfgWr,
  input  logic               cmpWr,
  input  logic               cntWr,
  input  logic [WORD_W-1:0]  wrData,
  input  logic               gEn,
  input  logic [WORD_W-1:0]  mainCnt,
  output logic [WORD_W-1:0]  cfgOut,
  output logic [WORD_W-1:0]  cmpOut,
  output logic [WORD_W-1:0]  perOut,
  output logic [ROUTE_W-1:0] route,
  output logic               fire
);

  localparam logic [WORD_W-1:0] PER_MASK_NARROW = 64'h0000_0000_7FFF_FFFF;
  localparam logic [WORD_W-1:0] PER_MASK_WIDE   = 64'h7FFF_FFFF_FFFF_FFFF;

  logic [CFG_W-1:0]  cfgR, cfgN, newCfg;
  logic [WORD_W-1:0] cmpR, cmpN, perR, perN;
  logic              armed, armN;
  logic              chEn, periodic, setv, narrow, match;
  logic [WORD_W-1:0] advSum, advVal, cmpIn, perMask;

  assign chEn     = cfgR[C_EN];
  assign periodic = cfgR[C_PERIODIC];
  assign setv     = cfgR[C_SETVAL];
  assign narrow   = cfgR[C_NARROW];
  assign route    = cfgR[C_ROUTE_LO +: ROUTE_W];

  assign match = narrow ? (cmpR[31:0] == mainCnt[31:0]) : (cmpR == mainCnt);
  assign fire  = armed && chEn && gEn && match;

  assign advSum  = cmpR + perR;
  assign advVal  = narrow ? {32'b0, advSum[31:0]} : advSum;
  assign cmpIn   = narrow ? {32'b0, wrData[31:0]} : wrData;
  assign perMask = narrow ? PER_MASK_NARROW : PER_MASK_WIDE;
  assign newCfg  = wrData[CFG_W-1:0] & C_WMASK;

  always_comb begin
    cfgN = cfgR;
    cmpN = cmpR;
    perN = perR;
    armN = armed;
    if (fire) begin
      if (periodic && (perR != '0)) cmpN = advVal;
      else                          armN = 1'b0;
    end
    if (cmpWr) begin
      cmpN = cmpIn;
      armN = 1'b1;
      if (setv)          cfgN[C_SETVAL] = 1'b0;
      else if (periodic) perN = cmpIn & perMask;
    end
    if (cntWr) armN = 1'b1;
    if (cfgWr) begin
      cfgN = newCfg;
      if (newCfg[C_NARROW]) begin
        cmpN[63:32] = '0;
        perN[63:32] = '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfgR  <= '0;
      cmpR  <= '1;
      perR  <= '0;
      armed <= 1'b1;
    end else begin
      cfgR  <= cfgN;
      cmpR  <= cmpN;
      perR  <= perN;
      armed <= armN;
    end
  end

  assign cfgOut = {{(WORD_W-CFG_W){1'b0}}, cfgR};
  assign cmpOut = cmpR;
  assign perOut = perR;

  AST_CMP_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
    narrow |-> (cmpR[63:32] == 32'b0)); // R6

  AST_PER_NARROW: assert property (@(posedge clk) disable iff (!rst_n)
    narrow |-> (perR[63:32] == 32'b0)); // R6

  AST_PER_TOP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    perR[63] == 1'b0); // R5

  AST_SETVAL_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (cmpWr && setv && !cfgWr) |=> !setv); // R4

  AST_SETVAL_KEEPS_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmpWr && setv && !cfgWr) |=> $stable(perR)); // R4

  AST_ONESHOT_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !periodic && !cmpWr && !cntWr) |=> !fire); // R9

  AST_PERIOD_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && periodic && (perR != '0) && !cmpWr && !cfgWr)
      |=> (cmpR[31:0] == $past(cmpR[31:0]) + $past(perR[31:0]))); // R8

endmodule

// File: rtl/evtmr_dp.sv
module evtmr_dp
  import evtmr_pkg::*;
#(
  parameter int NUM_CH   = 3,
  parameter int CH_IDX_W = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  strobes_t            stb,
  input  logic [NUM_CH-1:0]   chSel,
  input  logic                tick,
  input  logic [WORD_W-1:0]   wrData,
  input  logic [2:0]          rdTarget,
  input  logic [CH_IDX_W-1:0] rdChan,
  output logic [WORD_W-1:0]   rdData,
  output logic                gEn,
  output logic [NUM_IRQ-1:0]  irqOut
);

  logic                legacy;
  logic [WORD_W-1:0]   mainCnt;
  logic [NUM_CH-1:0]   status;
  logic [NUM_CH-1:0]   chFire;
  logic [ROUTE_W-1:0]  chRoute [NUM_CH];
  logic [ROUTE_W-1:0]  chLine  [NUM_CH];
  logic [WORD_W-1:0]   chCfg   [NUM_CH];
  logic [WORD_W-1:0]   chCmp   [NUM_CH];
  logic [WORD_W-1:0]   chPer   [NUM_CH];
  logic [NUM_IRQ-1:0]  irqNext;

  // global configuration and main counter
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gEn     <= 1'b0;
      legacy  <= 1'b0;
      mainCnt <= '0;
    end else begin
      if (stb.gCfgWr) begin
        gEn    <= wrData[G_EN];
        legacy <= wrData[G_LEGACY];
      end
      if (stb.cntWr)  mainCnt <= wrData;
      else if (tick)  mainCnt <= mainCnt + 1'b1;
    end
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    evtmr_chan u_chan (
      .clk     (clk),
      .rst_n   (rst_n),
      .cfgWr   (stb.chCfgWr && chSel[i]),
      .cmpWr   (stb.chCmpWr && chSel[i]),
      .cntWr   (stb.cntWr),
      .wrData  (wrData),
      .gEn     (gEn),
      .mainCnt (mainCnt),
      .cfgOut  (chCfg[i]),
      .cmpOut  (chCmp[i]),
      .perOut  (chPer[i]),
      .route   (chRoute[i]),
      .fire    (chFire[i])
    );

    if (i == 0) begin : g_leg0
      assign chLine[i] = legacy ? ROUTE_W'(LEGACY_LINE0) : chRoute[i];
    end else if (i == 1) begin : g_leg1
      assign chLine[i] = legacy ? ROUTE_W'(LEGACY_LINE1) : chRoute[i];
    end else begin : g_plain
      assign chLine[i] = chRoute[i];
    end

    always_ff @(posedge clk) begin
      if (!rst_n)                         status[i] <= 1'b0;
      else if (chFire[i])                 status[i] <= 1'b1;
      else if (stb.statWr && wrData[i])   status[i] <= 1'b0;
    end

    AST_FIRE_SETS_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
      chFire[i] |=> status[i]); // R7
  end

  always_comb begin
    irqNext = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (chFire[i]) irqNext[chLine[i]] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) irqOut <= '0;
    else        irqOut <= irqNext;
  end

  always_comb begin
    rdData = '0;
    case (rdTarget)
      RT_GCFG:   rdData = {{(WORD_W-2){1'b0}}, legacy, gEn};
      RT_COUNT:  rdData = mainCnt;
      RT_CHCFG:  if (int'(rdChan) < NUM_CH) rdData = chCfg[rdChan];
      RT_CHCMP:  if (int'(rdChan) < NUM_CH) rdData = chCmp[rdChan];
      RT_PERIOD: if (int'(rdChan) < NUM_CH) rdData = chPer[rdChan];
      RT_STATUS: rdData = {{(WORD_W-NUM_CH){1'b0}}, status};
      default:   rdData = '0;
    endcase
  end

  AST_CNT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!gEn && !stb.cntWr) |=> $stable(mainCnt)); // R1

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !stb.cntWr |=> ((mainCnt == $past(mainCnt)) || (mainCnt == $past(mainCnt) + 1'b1))); // R1

  AST_LEGACY_LINE0: assert property (@(posedge clk) disable iff (!rst_n)
    (legacy && chFire[0]) |=> irqOut[LEGACY_LINE0]); // R10

  AST_FIRE_PULSES: assert property (@(posedge clk) disable iff (!rst_n)
    (|chFire) |=> (irqOut != '0)); // R7

  AST_NO_SPURIOUS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    !(|chFire) |=> (irqOut == '0)); // R7

endmodule

// File: rtl/evtmr_top.sv
module evtmr_top
  import evtmr_pkg::*;
#(
  parameter int NUM_CH   = 3,
  parameter int PRESCALE = 16,
  parameter int CH_IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wrEn,
  input  logic [2:0]          wrTarget,
  input  logic [CH_IDX_W-1:0] wrChan,
  input  logic [63:0]         wrData,
  input  logic [2:0]          rdTarget,
  input  logic [CH_IDX_W-1:0] rdChan,
  output logic [63:0]         rdData,
  output logic [31:0]         irqOut
);

  strobes_t          stb;
  logic [NUM_CH-1:0] chSel;
  logic              tick;
  logic              gEn;

  evtmr_ctrl #(
    .NUM_CH   (NUM_CH),
    .PRESCALE (PRESCALE),
    .CH_IDX_W (CH_IDX_W)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .wrEn     (wrEn),
    .wrTarget (wrTarget),
    .wrChan   (wrChan),
    .gEn      (gEn),
    .stb      (stb),
    .chSel    (chSel),
    .tick     (tick)
  );

  evtmr_dp #(
    .NUM_CH   (NUM_CH),
    .CH_IDX_W (CH_IDX_W)
  ) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .stb      (stb),
    .chSel    (chSel),
    .tick     (tick),
    .wrData   (wrData),
    .rdTarget (rdTarget),
    .rdChan   (rdChan),
    .rdData   (rdData),
    .gEn      (gEn),
    .irqOut   (irqOut)
  );

endmodule

// File: tb/evtmr_top_tb.sv
module evtmr_top_tb_top;

  localparam logic [63:0] CFG_MASK = 64'h3F4C;
  localparam logic [63:0] LOW32    = 64'h0000_0000_FFFF_FFFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wrEn = 1'b0;
  logic [2:0]  wrTarget = '0;
  logic [1:0]  wrChan = '0;
  logic [63:0] wrData = '0;
  logic [2:0]  rdTarget = '0;
  logic [1:0]  rdChan = '0;
  logic [63:0] rdData;
  logic [31:0] irqOut;

  int checks = 0;
  int errors = 0;
  int pulseCnt [32];

  logic [63:0] mCfg [3];
  logic [63:0] mCmp [3];
  logic [63:0] mPer [3];

  always #2 clk = ~clk;

  evtmr_top dut_i (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .wrTarget(wrTarget), .wrChan(wrChan),
    .wrData(wrData), .rdTarget(rdTarget), .rdChan(rdChan), .rdData(rdData),
    .irqOut(irqOut)
  );

  initial for (int i = 0; i < 32; i++) pulseCnt[i] = 0;

  always @(negedge clk) begin
    for (int i = 0; i < 32; i++) if (irqOut[i]) pulseCnt[i] = pulseCnt[i] + 1;
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] tgt, input logic [1:0] ch, input logic [63:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrTarget = tgt; wrChan = ch; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] tgt, input logic [1:0] ch, output logic [63:0] d);
    rdTarget = tgt; rdChan = ch;
    #1;
    d = rdData;
  endtask

  task automatic waitCycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic logic [63:0] modelCmpIn(input int ch, input logic [63:0] d);
    return mCfg[ch][8] ? (d & LOW32) : d;
  endfunction

  initial begin
    repeat (1500000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [63:0] v, v2;
    int base5, base0, base3, base7, base8, base9;
    void'($urandom(32'd4242));
    waitCycles(3);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state
    rd(1, 0, v); check("R2 counter reset", v, 64'h0);
    rd(0, 0, v); check("R2 gcfg reset", v, 64'h0);
    rd(5, 0, v); check("R2 status reset", v, 64'h0);
    for (int c = 0; c < 3; c++) begin
      rd(3, c[1:0], v); check("R2 cmp reset", v, '1);
      rd(4, c[1:0], v); check("R2 period reset", v, 64'h0);
      rd(2, c[1:0], v); check("R2 cfg reset", v, 64'h0);
      mCfg[c] = '0; mCmp[c] = '1; mPer[c] = '0;
    end
    check("R2 irq reset", {32'b0, irqOut}, 64'h0);
    rd(6, 0, v); check("R13 unused read code", v, 64'h0);

    // R12 global config mask
    wr(0, 0, 64'hFFFF_FFFF_FFFF_FFFC);
    rd(0, 0, v); check("R12 gcfg mask", v, 64'h0);

    // constrained random register traffic with global enable clear
    for (int it = 0; it < 400; it++) begin
      int ch, op;
      logic [63:0] d;
      ch = $urandom % 3;
      op = $urandom % 3;
      d = {$urandom, $urandom};
      if (op == 0) begin
        wr(2, ch[1:0], d);
        mCfg[ch] = d & CFG_MASK;
        if (mCfg[ch][8]) begin
          mCmp[ch] = mCmp[ch] & LOW32;
          mPer[ch] = mPer[ch] & LOW32;
        end
      end else if (op == 1) begin
        wr(3, ch[1:0], d);
        v2 = modelCmpIn(ch, d);
        mCmp[ch] = v2;
        if (mCfg[ch][6]) mCfg[ch][6] = 1'b0;
        else if (mCfg[ch][3])
          mPer[ch] = v2 & (mCfg[ch][8] ? 64'h7FFF_FFFF : 64'h7FFF_FFFF_FFFF_FFFF);
      end else begin
        wr(1, 0, d);
        rd(1, 0, v); check("R2 counter load", v, d);
      end
      rd(2, ch[1:0], v); check("R12 R4 cfg model", v, mCfg[ch]);
      rd(3, ch[1:0], v); check("R3 R4 R6 cmp model", v, mCmp[ch]);
      rd(4, ch[1:0], v); check("R5 R6 period model", v, mPer[ch]);
    end
    rd(5, 0, v); check("R7 no firing while globally disabled", v, 64'h0);

    // directed SETVAL on a periodic channel
    wr(2, 1, 64'h8);
    wr(3, 1, 64'h4);
    wr(2, 1, 64'h48);
    wr(3, 1, 64'hA);
    rd(3, 1, v); check("R4 setval cmp", v, 64'hA);
    rd(4, 1, v); check("R4 setval period kept", v, 64'h4);
    rd(2, 1, v); check("R4 setval cleared", v, 64'h8);
    wr(3, 1, '1);
    rd(4, 1, v); check("R5 period top bit 64", v, 64'h7FFF_FFFF_FFFF_FFFF);
    wr(2, 1, 64'h108);
    rd(4, 1, v); check("R6 period truncated", v, 64'h7FFF_FFFF & LOW32 | 64'h8000_0000 & 64'hFFFF_FFFF);
    rd(3, 1, v); check("R6 cmp truncated", v, LOW32);
    wr(3, 1, '1);
    rd(4, 1, v); check("R5 period top bit 32", v, 64'h7FFF_FFFF);

    for (int c = 0; c < 3; c++) wr(2, c[1:0], 64'h0);

    // R1 counting
    wr(1, 0, 64'd100);
    wr(0, 0, 64'h1);
    waitCycles(80);
    rd(1, 0, v); check("R1 counts per 16 cycles", v, 64'd105);
    wr(0, 0, 64'h0);
    rd(1, 0, v);
    waitCycles(50);
    rd(1, 0, v2); check("R1 holds when disabled", v2, v);

    // R7 R9 one-shot on route 5
    wr(1, 0, 64'h0);
    wr(2, 0, 64'hA04);
    wr(3, 0, 64'd3);
    base5 = pulseCnt[5];
    wr(0, 0, 64'h1);
    waitCycles(48);
    check("R7 no pulse before match", {63'b0, irqOut[5]}, 64'h0);
    waitCycles(1);
    check("R7 pulse on route line", {63'b0, irqOut[5]}, 64'h1);
    rd(5, 0, v); check("R7 status set", v, 64'h1);
    waitCycles(1);
    check("R7 pulse one cycle", {63'b0, irqOut[5]}, 64'h0);
    waitCycles(40);
    check("R9 single pulse per match", pulseCnt[5] - base5, 1);
    rd(1, 0, v);
    wr(3, 0, v + 64'd3);
    waitCycles(80);
    check("R9 rearm by cmp write", pulseCnt[5] - base5, 2);
    wr(4, 0, 64'h2);
    rd(5, 0, v); check("R11 other bit kept", v, 64'h1);
    wr(4, 0, 64'h1);
    rd(5, 0, v); check("R11 status cleared", v, 64'h0);

    // R8 R10 periodic with legacy route
    wr(0, 0, 64'h2);
    wr(1, 0, 64'h0);
    wr(2, 0, 64'hA04);
    wr(3, 0, 64'd4);
    wr(2, 1, 64'h60C);
    wr(3, 1, 64'd2);
    rd(4, 1, v); check("R5 period captured", v, 64'd2);
    wr(2, 2, 64'hE04);
    wr(3, 2, 64'd5);
    base0 = pulseCnt[0]; base3 = pulseCnt[3]; base5 = pulseCnt[5];
    base7 = pulseCnt[7]; base8 = pulseCnt[8];
    wr(0, 0, 64'h3);
    waitCycles(176);
    check("R8 periodic pulse count", pulseCnt[8] - base8, 5);
    rd(3, 1, v); check("R8 comparator advanced", v, 64'd12);
    check("R10 legacy overrides ch1 route", pulseCnt[3] - base3, 0);
    check("R10 legacy ch0 line", pulseCnt[0] - base0, 1);
    check("R10 legacy overrides ch0 route", pulseCnt[5] - base5, 0);
    check("R10 ch2 keeps route", pulseCnt[7] - base7, 1);
    wr(0, 0, 64'h0);
    rd(5, 0, v); check("R7 status all channels", v, 64'h7);

    // R3 R7 narrow compare
    for (int c = 0; c < 3; c++) wr(2, c[1:0], 64'h0);
    wr(1, 0, 64'h1_0000_0002);
    wr(2, 2, 64'h1304);
    wr(3, 2, 64'hAAAA_0000_0000_0004);
    rd(3, 2, v); check("R3 narrow cmp write", v, 64'h4);
    base9 = pulseCnt[9];
    wr(0, 0, 64'h1);
    waitCycles(40);
    check("R7 narrow compare fires", pulseCnt[9] - base9, 1);
    wr(0, 0, 64'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule